// File: doc/BRIEF.md
# 64b/66b Block Encoder with Payload Scrambler

This block takes one 72-bit word per cycle and turns it into a 66-bit code word. The word is 64 data bits plus 8 per-byte control flags, built from two back-to-back 32-bit transfers with 4 control flags each. The code word is a 2-bit sync header followed by a 64-bit payload.

A word with no control flags set goes out as a data block. A word with control flags set is checked against the small set of legal control shapes and packed into a compact control block, with an 8-bit type byte and 7-bit codes for the control characters. A word that fits none of the legal shapes is replaced by an error block. The payload then passes through a self-synchronizing multiplicative scrambler, 1 + x^39 + x^58, and the header bypasses the scrambler unchanged.

The path has two register stages, encode and then scramble. A valid flag travels with the data, and the scrambler state moves only on valid words.

Top module: `pcs_block_encoder`

## Requirements
- R1: With `in_ctrl` all zero, the block is a data block: its header is 2'b01 and its descrambled payload equals `in_data`. Lane i is `in_data[8i+7:8i]`, and its flag is `in_ctrl[i]`.
- R2: Every valid output header is 2'b01 or 2'b10. It is 2'b10 whenever any control flag of the input was set.
- R3: If every lane is a control lane holding idle (0x07) or error (0xFE), the payload is type 0x1E in bits [7:0]. The 7-bit code for lane m sits at bit 8+7m, with idle coded as 0x00 and error as 0x1E.
- R4: A start character (0xFB) in lane 0, with only lane 0 flagged (`in_ctrl` = 0x01), gives type 0x78 followed by lanes 1 to 7 in bytes 1 to 7.
- R5: Lanes 0 to 3 as idle or error, a start in lane 4 and data in lanes 5 to 7 (`in_ctrl` = 0x1F) give type 0x33. The codes for lanes 0 to 3 sit at bit 8+7m, bits [39:36] are zero, and lanes 5 to 7 occupy bits [63:40].
- R6: A terminate (0xFD) in lane k, with data below it and idle or error above it (`in_ctrl` = 0xFF<<k), gives type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0..7. Data lane j sits at bit 8+8j, the code for lane m>k sits at bit 8+7m, and the pad bits are zero.
- R7: Any other pattern becomes the error block, type 0x1E with all eight codes 0x1E. This covers a start outside lanes 0 and 4, an unknown control character, and a control mask that fits no shape.
- R8: The payload is scrambled LSB first. Each output bit is the input bit XOR state[38] XOR state[57], and that output bit is then shifted into state[0]. After reset the state is all ones.
- R9: An input accepted in cycle n appears with `out_valid` in cycle n+2. The scrambler state does not change in cycles without a valid input.
- R10: While reset is asserted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 64 | Eight lanes of data or control characters |
| in_ctrl | input | 8 | Per-lane control flags |
| out_valid | output | 1 | Code word is valid |
| out_header | output | 2 | Sync header, not scrambled |
| out_payload | output | 64 | Scrambled payload |

## Verification
Two things can happen to the same word in one cycle: a legal shape is recognized, and that shape is rejected as illegal. A terminate whose trailing lane holds an unknown character, or a lane-4 start that also carries a flag on lane 5, almost matches a legal type. The bench drives such words alongside their legal neighbours and expects the error block, not the near-miss type. The bench also feeds words with idle gaps and back to back, descrambles every output with its own descrambler, and compares the decoded block with a reference encoding written from the requirements. Any scrambler state that moved during a gap shows up as a payload mismatch.

// File: rtl/enc66_pkg.sv
// Shared constants, types and helpers for the 64b/66b block encoder.
// Assumes eight byte lanes per block and 7-bit control codes.
package enc66_pkg;

    localparam int LANE_W = 8;
    localparam int CODE_W = 7;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_ERR   = 8'hFE;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;

    localparam logic [6:0] CODE_IDLE = 7'h00;
    localparam logic [6:0] CODE_ERR  = 7'h1E;

    localparam logic [7:0] TYPE_ALLCTL = 8'h1E;
    localparam logic [7:0] TYPE_START0 = 8'h78;
    localparam logic [7:0] TYPE_START4 = 8'h33;

    // Per-lane decode result
    typedef struct packed {
        logic       is_data;
        logic       is_code;
        logic       is_start;
        logic       is_term;
        logic [6:0] code;
    } lane_info_t;

    // Block type for a terminate in lane k
    function automatic logic [7:0] term_type(input int k);
        case (k)
            0:       return 8'h87;
            1:       return 8'h99;
            2:       return 8'hAA;
            3:       return 8'hB4;
            4:       return 8'hCC;
            5:       return 8'hD2;
            6:       return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/enc66_lane_decode.sv
// Classifies one byte lane as data, idle/error control, start, terminate
// or unknown control. Purely combinational; assumes the flag is per lane.
module enc66_lane_decode
    import enc66_pkg::*;
(
    input  logic [7:0] lane_byte,
    input  logic       lane_ctl,
    output lane_info_t info
);

    // Decode one lane into its class flags and 7-bit code
    always_comb begin
        info          = '0;
        info.is_data  = !lane_ctl;
        info.is_code  = lane_ctl && (lane_byte == CH_IDLE || lane_byte == CH_ERR);
        info.is_start = lane_ctl && (lane_byte == CH_START);
        info.is_term  = lane_ctl && (lane_byte == CH_TERM);
        info.code     = (lane_byte == CH_IDLE) ? CODE_IDLE : CODE_ERR;
    end

endmodule

// File: rtl/enc66_classify.sv
// Stage 1: maps a 72-bit input into a sync header and unscrambled payload.
// Illegal patterns become the error block. One register stage; the output
// holds its last value when no valid input arrives.
module enc66_classify
    import enc66_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctrl,
    output logic              enc_valid,
    output logic [1:0]        enc_header,
    output logic [DATA_W-1:0] enc_payload
);

    localparam int START4_LANE = LANES / 2;

    lane_info_t        li [LANES];
    logic [LANES-1:0]  code_ok;
    logic [1:0]        nxt_hdr;
    logic [DATA_W-1:0] nxt_pay;
    logic [DATA_W-1:0] err_pay;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            enc66_lane_decode u_lane (
                .lane_byte (in_data[LANE_W*g +: LANE_W]),
                .lane_ctl  (in_ctrl[g]),
                .info      (li[g])
            );
            assign code_ok[g] = li[g].is_code;
        end
    endgenerate

    // Build the error block payload: all codes set to the error code
    always_comb begin
        err_pay = '0;
        err_pay[7:0] = TYPE_ALLCTL;
        for (int m = 0; m < LANES; m++) begin
            err_pay[LANE_W + CODE_W*m +: CODE_W] = CODE_ERR;
        end
    end

    // Select the block shape and pack the payload
    always_comb begin
        logic             found;
        logic [LANES-1:0] hi_mask;
        logic [LANES-1:0] ctl_mask;
        found   = 1'b0;
        nxt_hdr = HDR_CTRL;
        nxt_pay = err_pay;
        hi_mask = '0;
        ctl_mask = '0;
        if (in_ctrl == '0) begin
            nxt_hdr = HDR_DATA;
            nxt_pay = in_data;
        end else if (&code_ok) begin
            nxt_pay = '0;
            nxt_pay[7:0] = TYPE_ALLCTL;
            for (int m = 0; m < LANES; m++) begin
                nxt_pay[LANE_W + CODE_W*m +: CODE_W] = li[m].code;
            end
        end else if (in_ctrl == LANES'(1) && li[0].is_start) begin
            nxt_pay = {in_data[DATA_W-1:LANE_W], TYPE_START0};
        end else if (in_ctrl == LANES'((1 << (START4_LANE + 1)) - 1)
                     && li[START4_LANE].is_start
                     && (&code_ok[START4_LANE-1:0])) begin
            nxt_pay = '0;
            nxt_pay[7:0] = TYPE_START4;
            for (int m = 0; m < START4_LANE; m++) begin
                nxt_pay[LANE_W + CODE_W*m +: CODE_W] = li[m].code;
            end
            nxt_pay[DATA_W-1:LANE_W*(START4_LANE+1)] =
                in_data[DATA_W-1:LANE_W*(START4_LANE+1)];
        end else begin
            for (int k = 0; k < LANES; k++) begin
                ctl_mask = {LANES{1'b1}} << k;
                hi_mask  = {LANES{1'b1}} << (k + 1);
                if (!found && in_ctrl == ctl_mask && li[k].is_term
                    && ((code_ok & hi_mask) == hi_mask)) begin
                    found   = 1'b1;
                    nxt_pay = '0;
                    nxt_pay[7:0] = term_type(k);
                    for (int j = 0; j < LANES; j++) begin
                        if (j < k) begin
                            nxt_pay[LANE_W + LANE_W*j +: LANE_W] = in_data[LANE_W*j +: LANE_W];
                        end
                    end
                    for (int m = 0; m < LANES; m++) begin
                        if (m > k) begin
                            nxt_pay[LANE_W + CODE_W*m +: CODE_W] = li[m].code;
                        end
                    end
                end
            end
        end
    end

    // Stage-1 register: capture the encoded block on valid input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid   <= 1'b0;
            enc_header  <= HDR_CTRL;
            enc_payload <= '0;
        end else begin
            enc_valid <= in_valid;
            if (in_valid) begin
                enc_header  <= nxt_hdr;
                enc_payload <= nxt_pay;
            end
        end
    end

    // R2: a data header only ever follows an input with no control flags
    p_data_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> ((enc_header == HDR_DATA) == ($past(in_ctrl) == '0)));

    // R4: type 0x78 only comes from a start character in lane 0
    p_start0_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && enc_header == HDR_CTRL && enc_payload[7:0] == TYPE_START0)
        |-> ($past(in_data[7:0]) == CH_START && $past(in_ctrl) == LANES'(1)));

    // R1: a data block carries the input bytes unchanged
    p_data_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && enc_header == HDR_DATA) |-> (enc_payload == $past(in_data)));

endmodule

// File: rtl/enc66_scrambler.sv
// Stage 2: multiplicative self-synchronizing scrambler over the payload,
// header passed around it. State advances only on valid blocks. Assumes
// the taps lie inside the state.
module enc66_scrambler #(
    parameter int DATA_W = 64,
    parameter int SCR_LEN = 58,
    parameter int TAP_A = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [1:0]        enc_header,
    input  logic [DATA_W-1:0] enc_payload,
    output logic              out_valid,
    output logic [1:0]        out_header,
    output logic [DATA_W-1:0] out_payload
);

    localparam int IDX_A = TAP_A - 1;
    localparam int IDX_B = SCR_LEN - 1;

    logic [SCR_LEN-1:0] state;
    logic [SCR_LEN-1:0] nxt_state;
    logic [DATA_W-1:0]  scr;

    // Scramble all payload bits LSB first within one cycle
    always_comb begin
        logic [SCR_LEN-1:0] s;
        s   = state;
        scr = '0;
        for (int i = 0; i < DATA_W; i++) begin
            scr[i] = enc_payload[i] ^ s[IDX_A] ^ s[IDX_B];
            s      = {s[SCR_LEN-2:0], scr[i]};
        end
        nxt_state = s;
    end

    // Stage-2 register and scrambler state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= '1;
            out_valid   <= 1'b0;
            out_header  <= 2'b10;
            out_payload <= '0;
        end else begin
            out_valid <= enc_valid;
            if (enc_valid) begin
                state       <= nxt_state;
                out_header  <= enc_header;
                out_payload <= scr;
            end
        end
    end

    // R9: scrambler state holds while no block is presented
    p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enc_valid) |-> $stable(state));

    // R8: the newest state bit equals the last scrambled payload bit
    p_state_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enc_valid) && out_valid) |-> (state[0] == out_payload[DATA_W-1]));

endmodule

// File: rtl/pcs_block_encoder.sv
// Top: two-stage 64b/66b block encoder (classify, then scramble).
// Input is one 72-bit word per cycle; output is header plus scrambled
// payload two cycles later with a matching valid.
module pcs_block_encoder #(
    parameter int DATA_W = 64,
    parameter int SCR_LEN = 58,
    parameter int TAP_A = 39,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctrl,
    output logic              out_valid,
    output logic [1:0]        out_header,
    output logic [DATA_W-1:0] out_payload
);

    logic              s1_valid;
    logic [1:0]        s1_header;
    logic [DATA_W-1:0] s1_payload;

    enc66_classify #(
        .DATA_W (DATA_W)
    ) u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ctrl     (in_ctrl),
        .enc_valid   (s1_valid),
        .enc_header  (s1_header),
        .enc_payload (s1_payload)
    );

    enc66_scrambler #(
        .DATA_W  (DATA_W),
        .SCR_LEN (SCR_LEN),
        .TAP_A   (TAP_A)
    ) u_scramble (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_valid   (s1_valid),
        .enc_header  (s1_header),
        .enc_payload (s1_payload),
        .out_valid   (out_valid),
        .out_header  (out_header),
        .out_payload (out_payload)
    );

    // R2: only the two legal sync values ever leave the block
    p_hdr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_header == 2'b01 || out_header == 2'b10));

    // R9: every encoded block reaches the output one cycle later
    p_stage_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);

    // R9: no output without an encoded block the cycle before
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));

    // R2: the header is carried through the scrambler stage unchanged
    p_hdr_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_header == $past(s1_header)));

endmodule

// File: tb/sim_pcs_block_encoder.sv
// Directed bench: reference encoding plus a descrambler on the output.
module sim_pcs_block_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        out_valid;
    logic [1:0]  out_header;
    logic [63:0] out_payload;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [65:0] exp_q[$];
    string       tag_q[$];
    logic [57:0] rx_state = '1;

    always #5 clk = ~clk;

    pcs_block_encoder u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_data (in_data), .in_ctrl (in_ctrl),
        .out_valid (out_valid), .out_header (out_header),
        .out_payload (out_payload)
    );

    task automatic check(input string req, input bit ok, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] code_of(input logic [7:0] b);
        return (b == 8'h07) ? 7'h00 : 7'h1E;
    endfunction

    function automatic bit is_ie(input logic [7:0] b, input bit c);
        return c && (b == 8'h07 || b == 8'hFE);
    endfunction

    // Reference encoder written from the requirements
    function automatic logic [65:0] ref_enc(input logic [63:0] d, input logic [7:0] c);
        logic [63:0] p;
        logic [7:0]  b [8];
        bit          ok;
        logic [7:0]  types [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
        for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
        if (c == 8'h00) return {2'b01, d};
        ok = 1'b1;
        for (int i = 0; i < 8; i++) ok = ok && is_ie(b[i], c[i]);
        if (ok) begin
            p = {56'h0, 8'h1E};
            for (int m = 0; m < 8; m++) p[8 + 7*m +: 7] = code_of(b[m]);
            return {2'b10, p};
        end
        if (c == 8'h01 && b[0] == 8'hFB) return {2'b10, d[63:8], 8'h78};
        if (c == 8'h1F && b[4] == 8'hFB) begin
            ok = 1'b1;
            for (int m = 0; m < 4; m++) ok = ok && is_ie(b[m], 1'b1);
            if (ok) begin
                p = {d[63:40], 32'h0, 8'h33};
                for (int m = 0; m < 4; m++) p[8 + 7*m +: 7] = code_of(b[m]);
                return {2'b10, p};
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (c == (8'hFF << k) && b[k] == 8'hFD) begin
                ok = 1'b1;
                for (int m = k + 1; m < 8; m++) ok = ok && is_ie(b[m], 1'b1);
                if (ok) begin
                    p = {56'h0, types[k]};
                    for (int j = 0; j < k; j++) p[8 + 8*j +: 8] = b[j];
                    for (int m = k + 1; m < 8; m++) p[8 + 7*m +: 7] = code_of(b[m]);
                    return {2'b10, p};
                end
            end
        end
        p = {56'h0, 8'h1E};
        for (int m = 0; m < 8; m++) p[8 + 7*m +: 7] = 7'h1E;
        return {2'b10, p};
    endfunction

    // Reference scrambler: returns scrambled payload for a given state
    function automatic logic [63:0] ref_scr(input logic [57:0] st, input logic [63:0] p);
        logic [63:0] o;
        for (int i = 0; i < 64; i++) begin
            o[i] = p[i] ^ st[38] ^ st[57];
            st   = {st[56:0], o[i]};
        end
        return o;
    endfunction

    // Output monitor: descramble and compare with the expected queue
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            logic [63:0] dp;
            logic [65:0] e;
            string       t;
            for (int i = 0; i < 64; i++) begin
                dp[i]    = out_payload[i] ^ rx_state[38] ^ rx_state[57];
                rx_state = {rx_state[56:0], out_payload[i]};
            end
            if (exp_q.size() == 0) begin
                check("R9", 1'b0, {out_header, dp}, '0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check("R2", out_header == e[65:64], {out_header, dp}, e);
                check(t, dp == e[63:0], {out_header, dp}, e);
            end
        end
    end

    task automatic send(input logic [63:0] d, input logic [7:0] c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_ctrl  = c;
        exp_q.push_back(ref_enc(d, c));
        tag_q.push_back(tag);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_0BAD_F00D;
            in_ctrl  = 8'h5A;
        end
    endtask

    task automatic drain(input string tag);
        gap(4);
        check(tag, exp_q.size() == 0, 66'(exp_q.size()), '0);
    endtask

    // R10: reset state of the output valid
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", out_valid == 1'b0, 66'(out_valid), '0);
        rst_n = 1'b1;
    endtask

    // R9 and R8: latency and exact scrambled value of the first block
    task automatic t_latency;
        logic [65:0] e;
        e = ref_enc(64'h0123_4567_89AB_CDEF, 8'h00);
        send(64'h0123_4567_89AB_CDEF, 8'h00, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", out_valid == 1'b0, 66'(out_valid), '0);
        @(posedge clk);
        #1;
        check("R9", out_valid == 1'b1, 66'(out_valid), 66'd1);
        check("R8", out_payload == ref_scr('1, e[63:0]), {out_header, out_payload}, {e[65:64], ref_scr('1, e[63:0])});
        drain("R9");
    endtask

    // R1: several data patterns
    task automatic t_data;
        send(64'h0, 8'h00, "R1");
        send('1, 8'h00, "R1");
        send(64'hA5A5_5A5A_F0F0_0F0F, 8'h00, "R1");
        send(64'h07FE_FBFD_07FE_FBFD, 8'h00, "R1");
        drain("R1");
    endtask

    // R3: idle / error control blocks
    task automatic t_idle;
        send({8{8'h07}}, 8'hFF, "R3");
        send({8{8'hFE}}, 8'hFF, "R3");
        send(64'h07FE_0707_FE07_07FE, 8'hFF, "R3");
        drain("R3");
    endtask

    // R4 and R5: starts in lane 0 and lane 4
    task automatic t_start;
        send(64'h5555_5555_5555_55FB, 8'h01, "R4");
        send(64'h1122_3344_5566_77FB, 8'h01, "R4");
        send(64'hAABB_CCFB_0707_0707, 8'h1F, "R5");
        send(64'h1234_56FB_FE07_FE07, 8'h1F, "R5");
        drain("R5");
    endtask

    // R6: terminate in every lane, with an error in the last trailing lane
    task automatic t_term;
        for (int k = 0; k < 8; k++) begin
            logic [63:0] d;
            d = 64'h8877_6655_4433_2211;
            d[8*k +: 8] = 8'hFD;
            for (int m = k + 1; m < 8; m++) d[8*m +: 8] = (m == 7) ? 8'hFE : 8'h07;
            send(d, 8'hFF << k, "R6");
        end
        drain("R6");
    endtask

    // R7: illegal patterns, including near-misses of legal shapes
    task automatic t_illegal;
        send(64'h0707_0707_07FB_0707, 8'hFF, "R7");
        send(64'h0000_0000_00FB_0000, 8'h04, "R7");
        send(64'h0707_0707_0707_079C, 8'hFF, "R7");
        send(64'h9C07_0707_FD33_2211, 8'hF8, "R7");
        send(64'h0707_0707_FD33_2211, 8'h78, "R7");
        send(64'hAABB_CCFB_0707_0707, 8'h3F, "R7");
        send(64'hAABB_CCFB_0707_FB07, 8'h1F, "R7");
        send(64'h1122_3344_5566_7707, 8'h01, "R7");
        drain("R7");
    endtask

    // R9: mixed stream with gaps and back-to-back blocks
    task automatic t_stream;
        for (int i = 0; i < 20; i++) begin
            send({32'(i * 32'h9E37_79B9), 32'(i ^ 32'h5A5A_1234)}, 8'h00, "R9");
            if (i % 3 == 0) gap(i % 5 + 1);
        end
        send({8{8'h07}}, 8'hFF, "R9");
        gap(2);
        send(64'h0707_0707_07FD_2211, 8'hFC, "R9");
        drain("R9");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_data();
        t_idle();
        t_start();
        t_term();
        t_illegal();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule